// File: doc/BRIEF.md
# Dual-Port DRAM Access Controller

This block lets two independent bus masters share a single DRAM bank. Each master raises its own request line and holds it. The controller decides which master is served and runs the row-strobe, column-enable and acknowledge sequence from one system clock. Periodic refresh cycles are fitted in between accesses. The 2×MA_W-bit master address is split into a row half and a column half, and these are sent in turn over an MA_W-bit multiplexed DRAM address bus. During refresh, that bus carries a row number from an internal counter.

Refresh is requested by the rising edge of a slow refresh clock that is asynchronous to the system clock. The edge passes through a synchroniser and is kept as a pending flag. Any pending refresh is served before a new port access. When both ports ask at once, the port that was not served last wins. The address can optionally be captured at the moment of the grant, so a master on a multiplexed or unheld bus may change its address lines once it sees the grant.

The request/grant pair works as the handshake. A master raises `reqN` and keeps it high until it has seen `dtack` with `grant` high and `port_sel` naming its port. Dropping the request ends the access. While a port waits, it is simply held off: no request is lost and none is queued beyond the level of the line.

Top module: `dram_dual_port_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `ras_n` is 1 and `grant`, `cas_en` and `dtack` are 0.
- R2: `grant` rises only for a port whose request was high at the deciding clock edge. `port_sel` (0 = port 0, 1 = port 1) names that port and does not change while `grant` stays high.
- R3: The row address (address bits MA_W-1:0) is on `ma` for at least one clock before `ras_n` falls. It stays unchanged in the clock in which `ras_n` falls.
- R4: One clock after `ras_n` falls in an access, `cas_en` rises and `ma` carries the column address (address bits 2×MA_W-1:MA_W). `cas_en` is never high while `ras_n` is high.
- R5: When both requests are high at the deciding edge, the port other than the one served last wins. Port 0 wins the first such contest after reset.
- R6: A refresh is a row-strobe-only cycle with `grant` and `cas_en` low. `ma` carries the refresh counter, which starts at 0 after reset and advances by 1 per refresh, wrapping modulo 2^MA_W.
- R7: Once `ras_n` goes high, it stays high for at least PRE_CYC clocks (default 2) before it may fall again.
- R8: `dtack` is high only while `grant` and `cas_en` are high. `grant` stays high for as long as the served port keeps its request high. `grant` falls one clock after that request is seen low in the acknowledge phase.
- R9: With LATCH_ADDR = 1, the address of the winning port is captured at the grant edge. Later changes on that port's address input do not affect the row or column placed on `ma`.
- R10: A rising edge on `rfsh_clk` is synchronised and held pending. A pending refresh is started before any port request that is waiting at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing derives from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| req0 | input | 1 | Access request from port 0, held until served |
| req1 | input | 1 | Access request from port 1, held until served |
| addr0 | input | 2×MA_W | Port 0 address (row in low half, column in high half) |
| addr1 | input | 2×MA_W | Port 1 address |
| rfsh_clk | input | 1 | Asynchronous refresh clock; each rising edge asks for one refresh |
| grant | output | 1 | A port owns the DRAM |
| port_sel | output | 1 | Port being served (0 or 1) |
| ras_n | output | 1 | Active-low row strobe |
| cas_en | output | 1 | Column strobe enable |
| dtack | output | 1 | Data-transfer acknowledge to the served port |
| ma | output | MA_W | Multiplexed row/column/refresh address |

## Verification
The checker watches strobe ordering on every clock: column enable only inside a row strobe, acknowledge only while granted, the precharge gap, address stability at the row-strobe fall, refresh without grant or column, and that grants follow requests and hold. What those properties cannot see are the values themselves: which row and column reach `ma`, whether round-robin alternation is correct, refresh-counter sequencing and wrap, the captured-address behaviour, and refresh winning over a waiting port. These are shown only by the bench, which compares each strobe against addresses and counts it tracks itself.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ROW,
    S_RAS,
    S_COL,
    S_ACK,
    S_PRE,
    S_RF_ROW,
    S_RF_RAS
  } dpc_state_e;

  typedef enum logic [1:0] {
    MA_ROW,
    MA_COL,
    MA_RFSH
  } ma_src_e;

endpackage

// File: rtl/dpc_rfsh_sync.sv
module dpc_rfsh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_clk_i,
  input  logic take_i,
  output logic pend_o
);

  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;
  logic            rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], rfsh_clk_i};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // a new edge wins over the clear so that no request is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (rise)   pend_o <= 1'b1;
    else if (take_i) pend_o <= 1'b0;
  end

endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic       commit_i,
  output logic       win_o,
  output logic       any_o
);

  logic last_q;

  always_comb begin
    any_o = |req_i;
    if (req_i == 2'b11) win_o = ~last_q;
    else                win_o = req_i[1];
  end

  // reset value 1 lets port 0 win the first contest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= 1'b1;
    else if (commit_i) last_q <= win_o;
  end

endmodule

// File: rtl/dpc_addr_path.sv
module dpc_addr_path
  import dpc_pkg::*;
#(
  parameter int MA_W       = 9,
  parameter bit LATCH_ADDR = 1'b1,
  localparam int AW        = 2 * MA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr0_i,
  input  logic [AW-1:0]   addr1_i,
  input  logic            cap_i,
  input  logic            cap_sel_i,
  input  logic            cur_sel_i,
  input  logic            rf_step_i,
  input  ma_src_e         src_i,
  output logic [MA_W-1:0] ma_o
);

  logic [AW-1:0]   act;
  logic [MA_W-1:0] rf_cnt_q;

  generate
    if (LATCH_ADDR) begin : g_latch
      logic [AW-1:0] held_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     held_q <= '0;
        else if (cap_i) held_q <= cap_sel_i ? addr1_i : addr0_i;
      end
      assign act = held_q;
    end else begin : g_live
      assign act = cur_sel_i ? addr1_i : addr0_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rf_cnt_q <= '0;
    else if (rf_step_i) rf_cnt_q <= rf_cnt_q + 1'b1;
  end

  always_comb begin
    unique case (src_i)
      MA_COL:  ma_o = act[AW-1:MA_W];
      MA_RFSH: ma_o = rf_cnt_q;
      default: ma_o = act[MA_W-1:0];
    endcase
  end

endmodule

// File: rtl/dpc_sequencer.sv
module dpc_sequencer
  import dpc_pkg::*;
#(
  parameter int PRE_CYC    = 2,
  parameter int RF_RAS_CYC = 2,
  localparam int MAXC      = (PRE_CYC > RF_RAS_CYC) ? PRE_CYC : RF_RAS_CYC,
  localparam int CNT_W     = $clog2(MAXC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic       any_i,
  input  logic       win_i,
  input  logic       rf_pend_i,
  output logic       rf_take_o,
  output logic       commit_o,
  output logic       port_sel_o,
  output logic       grant_o,
  output logic       ras_n_o,
  output logic       cas_en_o,
  output logic       dtack_o,
  output logic       rf_step_o,
  output ma_src_e    src_o
);

  dpc_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (rf_pend_i) st_q <= S_RF_ROW;
          else if (any_i) begin
            st_q  <= S_ROW;
            sel_q <= win_i;
          end
        end
        S_ROW: st_q <= S_RAS;
        S_RAS: st_q <= S_COL;
        S_COL: st_q <= S_ACK;
        S_ACK: begin
          if (!req_i[sel_q]) begin
            st_q  <= S_PRE;
            cnt_q <= CNT_W'(PRE_CYC - 1);
          end
        end
        S_PRE: begin
          if (cnt_q == '0) st_q <= S_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        S_RF_ROW: begin
          st_q  <= S_RF_RAS;
          cnt_q <= CNT_W'(RF_RAS_CYC - 1);
        end
        S_RF_RAS: begin
          if (cnt_q == '0) begin
            st_q  <= S_PRE;
            cnt_q <= CNT_W'(PRE_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_take_o  = (st_q == S_IDLE) && rf_pend_i;
    commit_o   = (st_q == S_IDLE) && !rf_pend_i && any_i;
    rf_step_o  = (st_q == S_RF_RAS) && (cnt_q == '0);
    port_sel_o = sel_q;
    grant_o    = (st_q == S_ROW) || (st_q == S_RAS) ||
                 (st_q == S_COL) || (st_q == S_ACK);
    ras_n_o    = !((st_q == S_RAS) || (st_q == S_COL) ||
                   (st_q == S_ACK) || (st_q == S_RF_RAS));
    cas_en_o   = (st_q == S_COL) || (st_q == S_ACK);
    dtack_o    = (st_q == S_ACK);
    unique case (st_q)
      S_COL, S_ACK:       src_o = MA_COL;
      S_RF_ROW, S_RF_RAS: src_o = MA_RFSH;
      default:            src_o = MA_ROW;
    endcase
  end

endmodule

// File: rtl/dram_dual_port_ctrl.sv
module dram_dual_port_ctrl
  import dpc_pkg::*;
#(
  parameter int MA_W        = 9,
  parameter int PRE_CYC     = 2,
  parameter int RF_RAS_CYC  = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit LATCH_ADDR  = 1'b1,
  localparam int AW         = 2 * MA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req0,
  input  logic            req1,
  input  logic [AW-1:0]   addr0,
  input  logic [AW-1:0]   addr1,
  input  logic            rfsh_clk,
  output logic            grant,
  output logic            port_sel,
  output logic            ras_n,
  output logic            cas_en,
  output logic            dtack,
  output logic [MA_W-1:0] ma
);

  logic [1:0] req_v;
  logic       rf_pend, rf_take, commit, win, any_req, rf_step;
  ma_src_e    src;

  assign req_v = {req1, req0};

  dpc_rfsh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rfsh_clk_i (rfsh_clk),
    .take_i     (rf_take),
    .pend_o     (rf_pend)
  );

  dpc_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_v),
    .commit_i (commit),
    .win_o    (win),
    .any_o    (any_req)
  );

  dpc_sequencer #(.PRE_CYC(PRE_CYC), .RF_RAS_CYC(RF_RAS_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_v),
    .any_i      (any_req),
    .win_i      (win),
    .rf_pend_i  (rf_pend),
    .rf_take_o  (rf_take),
    .commit_o   (commit),
    .port_sel_o (port_sel),
    .grant_o    (grant),
    .ras_n_o    (ras_n),
    .cas_en_o   (cas_en),
    .dtack_o    (dtack),
    .rf_step_o  (rf_step),
    .src_o      (src)
  );

  dpc_addr_path #(.MA_W(MA_W), .LATCH_ADDR(LATCH_ADDR)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr0_i   (addr0),
    .addr1_i   (addr1),
    .cap_i     (commit),
    .cap_sel_i (win),
    .cur_sel_i (port_sel),
    .rf_step_i (rf_step),
    .src_i     (src),
    .ma_o      (ma)
  );

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int MA_W    = 9,
  parameter int PRE_CYC = 2,
  localparam int HW     = $clog2(PRE_CYC + 1) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req0,
  input logic            req1,
  input logic            grant,
  input logic            port_sel,
  input logic            ras_n,
  input logic            cas_en,
  input logic            dtack,
  input logic [MA_W-1:0] ma
);

  // saturating count of clocks with the row strobe high
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_cnt <= HW'(PRE_CYC);
    else if (!ras_n)                  hi_cnt <= '0;
    else if (hi_cnt < HW'(PRE_CYC))   hi_cnt <= hi_cnt + 1'b1;
  end

  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> (port_sel ? $past(req1) : $past(req0))); // R2
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && $past(grant)) |-> $stable(port_sel)); // R2
  AST_ROW_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(ma)); // R3
  AST_CAS_IN_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    cas_en |-> !ras_n); // R4
  AST_COL_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_en) |-> $past(!ras_n)); // R4
  AST_RF_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !grant) |-> !cas_en); // R6
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= HW'(PRE_CYC))); // R7
  AST_DTACK_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    dtack |-> (grant && cas_en)); // R8
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (port_sel ? req1 : req0)) |=> grant); // R8

endmodule

bind dram_dual_port_ctrl dpc_checker #(.MA_W(MA_W), .PRE_CYC(PRE_CYC)) u_dpc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req0     (req0),
  .req1     (req1),
  .grant    (grant),
  .port_sel (port_sel),
  .ras_n    (ras_n),
  .cas_en   (cas_en),
  .dtack    (dtack),
  .ma       (ma)
);

// File: tb/dram_dual_port_ctrl_bench.sv
`timescale 1ns/1ps
module dram_dual_port_ctrl_bench;

  localparam int MA_W    = 9;
  localparam int AW      = 2 * MA_W;
  localparam int PRE_CYC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]      req = 2'b00;
  logic [AW-1:0]   abus [2];
  logic            rfsh = 1'b0;
  logic            grant, port_sel, ras_n, cas_en, dtack;
  logic [MA_W-1:0] ma;

  dram_dual_port_ctrl u_dram_dual_port_ctrl (
    .clk(clk), .rst_n(rst_n), .req0(req[0]), .req1(req[1]),
    .addr0(abus[0]), .addr1(abus[1]), .rfsh_clk(rfsh),
    .grant(grant), .port_sel(port_sel), .ras_n(ras_n),
    .cas_en(cas_en), .dtack(dtack), .ma(ma)
  );

  int n_vec = 0, n_bad = 0, n_rf = 0;
  bit done = 1'b0;
  logic prev_ras = 1'b1, prev_cas = 1'b0, prev_grant = 1'b0, prev_sel = 1'b0;
  int hi_run = 100;
  logic [MA_W-1:0] rf_exp = '0;
  logic last_sel = 1'b1;
  logic [AW-1:0] adr [2];
  bit acked [2];
  int hold [2];
  bit rand_en = 0, auto_drop = 0, rf_auto = 0;
  int rf_half = 20, rf_tick = 0;
  bit fell_now = 0, fell_grant = 0;

  function automatic logic [MA_W-1:0] row_of(input logic [AW-1:0] a);
    return a[MA_W-1:0];
  endfunction
  function automatic logic [MA_W-1:0] col_of(input logic [AW-1:0] a);
    return a[AW-1:MA_W];
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
  endtask

  task automatic set_req(input int p);
    adr[p]  = AW'($urandom);
    abus[p] = adr[p];
    req[p]  = 1'b1;
  endtask

  task automatic step();
    @(negedge clk);
    fell_now = prev_ras && !ras_n;
    if (fell_now) begin
      fell_grant = grant;
      chk(hi_run >= PRE_CYC, "R7 precharge", hi_run, PRE_CYC);
      if (grant) begin
        // R3 row at strobe fall, R9 taken from captured address
        chk(ma == row_of(adr[port_sel]), "R3 R9 row", ma, row_of(adr[port_sel]));
      end else begin
        chk(ma == rf_exp && !cas_en, "R6 refresh row", ma, rf_exp);
        rf_exp = rf_exp + 1'b1;
        n_rf++;
      end
    end
    hi_run = ras_n ? hi_run + 1 : 0;
    if (cas_en && !prev_cas)
      chk(ma == col_of(adr[port_sel]) && !ras_n, "R4 column", ma, col_of(adr[port_sel]));
    if (grant && !prev_grant) begin
      chk(req[port_sel] == 1'b1, "R2 grant to requester", req, port_sel);
      if (req == 2'b11) chk(port_sel != last_sel, "R5 round robin", port_sel, ~last_sel);
      last_sel = port_sel;
      abus[port_sel] = ~adr[port_sel];  // R9: bus changes after grant
    end
    if (!grant && prev_grant)
      chk(req[prev_sel] == 1'b0, "R8 grant released", req, 0);
    if (dtack && !grant)
      chk(1'b0, "R8 dtack without grant", dtack, 0);
    prev_ras = ras_n; prev_cas = cas_en; prev_grant = grant; prev_sel = port_sel;
    for (int p = 0; p < 2; p++) begin
      if (!req[p]) begin
        if (rand_en && $urandom_range(0, 3) == 0) set_req(p);
      end else if (auto_drop && dtack && grant && port_sel == p) begin
        if (!acked[p]) begin
          acked[p] = 1'b1;
          hold[p]  = $urandom_range(0, 2);
        end else if (hold[p] == 0) begin
          req[p]   = 1'b0;
          acked[p] = 1'b0;
        end else begin
          hold[p]--;
        end
      end
    end
    if (rf_auto) begin
      rf_tick++;
      if (rf_tick >= rf_half) begin
        rf_tick = 0;
        rfsh = ~rfsh;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    int rf_start;
    void'($urandom(32'd20240611));
    abus[0] = '0; abus[1] = '0; adr[0] = '0; adr[1] = '0;
    acked[0] = 0; acked[1] = 0; hold[0] = 0; hold[1] = 0;
    repeat (3) @(negedge clk);
    chk(ras_n && !grant && !cas_en && !dtack, "R1 reset state",
        {ras_n, grant, cas_en, dtack}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && !grant && !cas_en && !dtack, "R1 after reset",
        {ras_n, grant, cas_en, dtack}, 4'b1000);

    // random traffic from both ports with background refresh
    rand_en = 1; auto_drop = 1; rf_auto = 1; rf_half = 20;
    repeat (6000) step();
    rand_en = 0; rf_auto = 0; rfsh = 1'b0;
    repeat (80) step();

    // R5: simultaneous requests from idle, twice
    for (int k = 0; k < 2; k++) begin
      set_req(0); set_req(1);
      repeat (60) step();
    end

    // R10: refresh pending while port 0 is served, port 1 waiting
    auto_drop = 0;
    set_req(0);
    for (int k = 0; k < 40; k++) begin
      step();
      if (dtack && port_sel == 1'b0) break;
    end
    rfsh = 1'b1;
    repeat (6) step();
    set_req(1);
    req[0] = 1'b0;
    fell_now = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (fell_now) break;
    end
    chk(fell_now && !fell_grant, "R10 refresh first", {fell_now, fell_grant}, 2'b10);
    auto_drop = 1;
    repeat (40) step();
    rfsh = 1'b0;
    repeat (10) step();

    // R6: counter wrap with refresh only
    rf_start = n_rf;
    rf_auto = 1; rf_half = 6; rf_tick = 0;
    repeat (6500) step();
    chk(n_rf - rf_start > (1 << MA_W), "R6 refresh count past wrap", n_rf - rf_start, 1 << MA_W);

    report();
    $finish;
  end

endmodule